// File: doc/BRIEF.md
# Command Processor Microcode ALU

This block is the arithmetic and logic unit of a small microcontroller that interprets a command stream. Every cycle it takes an operation code, a first operand and a second operand, and it produces a 32-bit result within the same cycle. The second operand comes from either a register value or an immediate. A select input chooses between them, and every operation computes the same function whichever source is chosen. Decode, register-file access and branching are handled elsewhere. The unit receives already-decoded field positions for the bitfield operations.

The operations are low-word and high-word add and subtract for 64-bit arithmetic, the bitwise set including inverse and AND-NOT, three shift forms, a left rotate, an 8-bit multiply, unsigned minimum, maximum and a three-way compare, bit set and clear, field extract and insert, and the index of the most significant set bit. A single registered flag carries the carry or borrow out of the low-word step into the high-word step. It is kept as a two-state machine. FLAG_CLEAR and FLAG_SET are the states. A LATCH_SET transition goes from FLAG_CLEAR to FLAG_SET when a valid arithmetic operation produces a carry or borrow. A LATCH_CLR transition goes from FLAG_SET to FLAG_CLEAR when a valid arithmetic operation produces none. HOLD keeps the current state on every other cycle. Reset enters FLAG_CLEAR.

Top module: `cp_ucode_alu`

## Requirements
- R1: When use_imm is 1 the second operand is imm, otherwise it is src2. The unselected input has no effect on result or carry.
- R2: ADD (code 1) returns the low 32 bits of src1 plus operand and latches the carry-out. SUB (code 3) returns src1 minus operand and latches a borrow, which is 1 when src1 is below the operand as unsigned values.
- R3: ADDX (code 2) adds the flag as a carry-in, and SUBX (code 4) subtracts the flag as a borrow-in. Each latches its own carry or borrow, so ADD then ADDX, or SUB then SUBX, gives correct 64-bit arithmetic.
- R4: carry is 0 after reset. It changes only on the clock edge after an op_valid cycle whose code is 1 to 4. All other codes, and cycles with op_valid at 0, leave it unchanged.
- R5: AND (5), OR (6), XOR (7) and ANDN (17, src1 AND the inverse of the operand) are bitwise. INV (8) returns the inverse of the operand and ignores src1.
- R6: The shift count is operand bits 4:0. SHL (9) shifts src1 left, SHRL (10) shifts it right with zero fill, SHRA (11) shifts it right replicating bit 31, and ROTL (12) rotates it left, with bit 31 wrapping into bit 0.
- R7: MUL8 (13) returns the product of the low 8 bits of src1 and of the operand, zero-extended from 16 bits.
- R8: MIN (14) and MAX (15) compare as unsigned. CMP (16) returns 0 when the values are equal, 1 when src1 is greater, and 2 when src1 is less.
- R9: With index equal to operand bits 4:0, BITDYN (18) sets that bit of src1 when operand bit 5 is 1 and clears it when bit 5 is 0. BITSET (19) sets the bit and BITCLR (20) clears it.
- R10: FEXT (21) returns src1 bits fld_hi down to fld_lo, right-aligned and zero-extended. It returns 0 when fld_hi is below fld_lo.
- R11: FINS (22) returns src1 with bits fld_hi..fld_lo replaced by the low bits of the operand, and all other bits kept. It returns src1 unchanged when fld_hi is below fld_lo.
- R12: MSB (23) returns the index of the highest set bit of the operand and ignores src1. It returns 0 for an operand of 0.
- R13: NOP (0) and the unassigned codes 24 to 31 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flag |
| op_valid | input | 1 | The operation on the inputs is issued this cycle |
| opcode | input | 5 | Operation code |
| use_imm | input | 1 | Selects imm rather than src2 as the second operand |
| src1 | input | 32 | First operand |
| src2 | input | 32 | Register second operand |
| imm | input | 32 | Immediate second operand |
| fld_lo | input | 5 | Low bit position for FEXT and FINS |
| fld_hi | input | 5 | High bit position for FEXT and FINS |
| result | output | 32 | Combinational result |
| carry | output | 1 | Registered carry or borrow flag |

## Verification
The hardest situation to reach from the ports is a high-word step that depends on a flag set several cycles earlier. Non-arithmetic operations and idle cycles sit between the two steps, so only the HOLD transition can have kept the flag. The stimulus builds 64-bit chains whose low words are all ones or zero, so the carry or borrow must propagate through the whole high word. Between the low-word and high-word steps it places logic operations and arithmetic codes with op_valid at 0. The flag is then forced through LATCH_SET and LATCH_CLR in both orders. A long random phase then compares every cycle against the bench model.

// File: rtl/cp_alu_pkg.sv
`timescale 1ns/1ps
package cp_alu_pkg;

    typedef enum logic [4:0] {
        OP_NOP    = 5'd0,
        OP_ADD    = 5'd1,
        OP_ADDX   = 5'd2,
        OP_SUB    = 5'd3,
        OP_SUBX   = 5'd4,
        OP_AND    = 5'd5,
        OP_OR     = 5'd6,
        OP_XOR    = 5'd7,
        OP_INV    = 5'd8,
        OP_SHL    = 5'd9,
        OP_SHRL   = 5'd10,
        OP_SHRA   = 5'd11,
        OP_ROTL   = 5'd12,
        OP_MUL8   = 5'd13,
        OP_MIN    = 5'd14,
        OP_MAX    = 5'd15,
        OP_CMP    = 5'd16,
        OP_ANDN   = 5'd17,
        OP_BITDYN = 5'd18,
        OP_BITSET = 5'd19,
        OP_BITCLR = 5'd20,
        OP_FEXT   = 5'd21,
        OP_FINS   = 5'd22,
        OP_MSB    = 5'd23
    } alu_op_e;

    typedef enum logic {
        FLAG_CLEAR = 1'b0,
        FLAG_SET   = 1'b1
    } flag_state_e;

    function automatic logic is_carry_op(alu_op_e op);
        return (op == OP_ADD) || (op == OP_ADDX) || (op == OP_SUB) || (op == OP_SUBX);
    endfunction

endpackage

// File: rtl/cp_alu_arith.sv
`timescale 1ns/1ps
module cp_alu_arith
    import cp_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           flag_in,
    output logic [W-1:0]   arith_res,
    output logic           carry_out
);

    logic           chain_in;
    logic [W:0]     sum_w;
    logic [W:0]     dif_w;

    always_comb begin
        chain_in = ((op == OP_ADDX) || (op == OP_SUBX)) ? flag_in : 1'b0;
        sum_w    = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, chain_in};
        dif_w    = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, chain_in};
    end

    always_comb begin
        arith_res = '0;
        carry_out = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDX: begin
                arith_res = sum_w[W-1:0];
                carry_out = sum_w[W];
            end
            OP_SUB, OP_SUBX: begin
                arith_res = dif_w[W-1:0];
                carry_out = dif_w[W];
            end
            OP_MIN:  arith_res = (a < b) ? a : b;
            OP_MAX:  arith_res = (a > b) ? a : b;
            OP_CMP: begin
                if (a == b)     arith_res = '0;
                else if (a > b) arith_res = W'(1);
                else            arith_res = W'(2);
            end
            default: begin
                arith_res = '0;
                carry_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/cp_alu_logic.sv
`timescale 1ns/1ps
module cp_alu_logic
    import cp_alu_pkg::*;
#(
    parameter int W  = 32,
    parameter int FW = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [W-1:0]   logic_res
);

    localparam int SW = $clog2(W);

    logic [SW-1:0]    sh_amt;
    logic [2*W-1:0]   rot_w;
    logic [2*FW-1:0]  prod;
    logic [W-1:0]     bit_m;

    always_comb begin
        sh_amt = b[SW-1:0];
        rot_w  = {a, a} << sh_amt;
        prod   = a[FW-1:0] * b[FW-1:0];
        bit_m  = W'(1) << sh_amt;
    end

    always_comb begin
        logic_res = '0;
        unique case (op)
            OP_AND:    logic_res = a & b;
            OP_OR:     logic_res = a | b;
            OP_XOR:    logic_res = a ^ b;
            OP_INV:    logic_res = ~b;
            OP_ANDN:   logic_res = a & ~b;
            OP_SHL:    logic_res = a << sh_amt;
            OP_SHRL:   logic_res = a >> sh_amt;
            OP_SHRA:   logic_res = $unsigned($signed(a) >>> sh_amt);
            OP_ROTL:   logic_res = rot_w[2*W-1:W];
            OP_MUL8:   logic_res = {{(W-2*FW){1'b0}}, prod};
            OP_BITDYN: logic_res = b[SW] ? (a | bit_m) : (a & ~bit_m);
            OP_BITSET: logic_res = a | bit_m;
            OP_BITCLR: logic_res = a & ~bit_m;
            default:   logic_res = '0;
        endcase
    end

endmodule

// File: rtl/cp_alu_field.sv
`timescale 1ns/1ps
module cp_alu_field #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [SW-1:0]  lo,
    input  logic [SW-1:0]  hi,
    output logic [W-1:0]   fext_res,
    output logic [W-1:0]   fins_res,
    output logic [SW-1:0]  msb_idx
);

    logic [W-1:0] fmask;

    for (genvar i = 0; i < W; i++) begin : g_mask
        localparam logic [SW-1:0] POS = SW'(i);
        assign fmask[i] = (POS >= lo) && (POS <= hi);
    end

    always_comb begin
        fext_res = (a & fmask) >> lo;
        fins_res = (a & ~fmask) | ((b << lo) & fmask);
    end

    always_comb begin
        msb_idx = '0;
        for (int k = 0; k < W; k++) begin
            if (b[k]) msb_idx = SW'(k);
        end
    end

endmodule

// File: rtl/cp_alu_flag.sv
`timescale 1ns/1ps
module cp_alu_flag
    import cp_alu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd,
    input  logic carry_in,
    output logic flag
);

    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_CLEAR: if (upd && carry_in)  state_d = FLAG_SET;
            FLAG_SET:   if (upd && !carry_in) state_d = FLAG_CLEAR;
            default:    state_d = FLAG_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_SET);
    end

endmodule

// File: rtl/cp_ucode_alu.sv
`timescale 1ns/1ps
module cp_ucode_alu
    import cp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 8,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        opcode,
    input  logic              use_imm,
    input  logic [DATA_W-1:0] src1,
    input  logic [DATA_W-1:0] src2,
    input  logic [DATA_W-1:0] imm,
    input  logic [POS_W-1:0]  fld_lo,
    input  logic [POS_W-1:0]  fld_hi,
    output logic [DATA_W-1:0] result,
    output logic              carry
);

    alu_op_e           op;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] arith_res;
    logic              arith_co;
    logic [DATA_W-1:0] logic_res;
    logic [DATA_W-1:0] fext_res;
    logic [DATA_W-1:0] fins_res;
    logic [POS_W-1:0]  msb_idx;
    logic              flag_upd;

    assign op       = alu_op_e'(opcode);
    assign opnd_b   = use_imm ? imm : src2;
    assign flag_upd = op_valid && is_carry_op(op);

    cp_alu_arith #(.W(DATA_W)) u_arith (
        .op        (op),
        .a         (src1),
        .b         (opnd_b),
        .flag_in   (carry),
        .arith_res (arith_res),
        .carry_out (arith_co)
    );

    cp_alu_logic #(.W(DATA_W), .FW(MUL_W)) u_logic (
        .op        (op),
        .a         (src1),
        .b         (opnd_b),
        .logic_res (logic_res)
    );

    cp_alu_field #(.W(DATA_W), .SW(POS_W)) u_field (
        .a        (src1),
        .b        (opnd_b),
        .lo       (fld_lo),
        .hi       (fld_hi),
        .fext_res (fext_res),
        .fins_res (fins_res),
        .msb_idx  (msb_idx)
    );

    cp_alu_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (flag_upd),
        .carry_in (arith_co),
        .flag     (carry)
    );

    always_comb begin
        result = '0;
        unique case (op)
            OP_ADD, OP_ADDX, OP_SUB, OP_SUBX,
            OP_MIN, OP_MAX, OP_CMP:                  result = arith_res;
            OP_AND, OP_OR, OP_XOR, OP_INV, OP_ANDN,
            OP_SHL, OP_SHRL, OP_SHRA, OP_ROTL,
            OP_MUL8, OP_BITDYN, OP_BITSET, OP_BITCLR: result = logic_res;
            OP_FEXT:                                 result = fext_res;
            OP_FINS:                                 result = fins_res;
            OP_MSB:                                  result = {{(DATA_W-POS_W){1'b0}}, msb_idx};
            default:                                 result = '0;
        endcase
    end

endmodule

// File: rtl/cp_ucode_alu_chk.sv
`timescale 1ns/1ps
module cp_ucode_alu_chk
    import cp_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 8,
    parameter int POS_W  = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [4:0]        opcode,
    input logic              use_imm,
    input logic [DATA_W-1:0] src1,
    input logic [DATA_W-1:0] src2,
    input logic [DATA_W-1:0] imm,
    input logic [DATA_W-1:0] result,
    input logic              carry
);

    logic [DATA_W-1:0] b_sel;
    logic              arith_code;
    assign b_sel      = use_imm ? imm : src2;
    assign arith_code = (opcode >= 5'd1) && (opcode <= 5'd4);

    // R4
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && arith_code) |=> $stable(carry));

    // R2
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_ADD) |=> (carry == $past(result < src1)));

    // R2
    sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == OP_SUB) |=> (carry == $past(src1 < b_sel)));

    // R8
    cmp_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_CMP) |-> (result <= DATA_W'(2)));

    // R7
    mul_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_MUL8) |-> ((result >> (2*MUL_W)) == '0));

    // R5
    inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_INV) |-> ((result ^ b_sel) == '1));

    // R12
    msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_MSB && b_sel != '0) |-> ((b_sel >> result[POS_W-1:0]) == DATA_W'(1)));

    // R13
    spare_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_NOP || opcode > 5'd23) |-> (result == '0));

endmodule

bind cp_ucode_alu cp_ucode_alu_chk #(.DATA_W(DATA_W), .MUL_W(MUL_W), .POS_W(POS_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .opcode   (opcode),
    .use_imm  (use_imm),
    .src1     (src1),
    .src2     (src2),
    .imm      (imm),
    .result   (result),
    .carry    (carry)
);

// File: tb/tb_cp_ucode_alu.sv
`timescale 1ns/1ps
module tb_cp_ucode_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  opcode = 5'd0;
    logic        use_imm = 1'b0;
    logic [31:0] src1 = '0;
    logic [31:0] src2 = '0;
    logic [31:0] imm = '0;
    logic [4:0]  fld_lo = '0;
    logic [4:0]  fld_hi = '0;
    logic [31:0] result;
    logic        carry;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit m_flag = 0;

    always #2 clk = ~clk;

    cp_ucode_alu dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
        .use_imm(use_imm), .src1(src1), .src2(src2), .imm(imm),
        .fld_lo(fld_lo), .fld_hi(fld_hi), .result(result), .carry(carry)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] model(int opc, logic [31:0] a, logic [31:0] b,
                                          int lo, int hi, bit fin, output bit co);
        logic [63:0] w;
        logic [31:0] r;
        int sh;
        sh = int'(b[4:0]);
        co = 0;
        r  = 0;
        case (opc)
            1, 2: begin
                w  = {32'd0, a} + {32'd0, b} + ((opc == 2 && fin) ? 64'd1 : 64'd0);
                r  = w[31:0];
                co = w[32];
            end
            3, 4: begin
                w  = {32'd0, a} - {32'd0, b} - ((opc == 4 && fin) ? 64'd1 : 64'd0);
                r  = w[31:0];
                co = w[63];
            end
            5:  r = a & b;
            6:  r = a | b;
            7:  r = a ^ b;
            8:  r = ~b;
            9:  begin r = a; repeat (sh) r = {r[30:0], 1'b0}; end
            10: begin r = a; repeat (sh) r = {1'b0, r[31:1]}; end
            11: begin r = a; repeat (sh) r = {r[31], r[31:1]}; end
            12: begin r = a; repeat (sh) r = {r[30:0], r[31]}; end
            13: r = 32'(int'(a[7:0]) * int'(b[7:0]));
            14: r = (a <= b) ? a : b;
            15: r = (a >= b) ? a : b;
            16: r = (a == b) ? 32'd0 : ((a > b) ? 32'd1 : 32'd2);
            17: r = a & ~b;
            18: begin r = a; r[sh] = b[5]; end
            19: begin r = a; r[sh] = 1'b1; end
            20: begin r = a; r[sh] = 1'b0; end
            21: begin
                for (int k = lo; k <= hi; k++) r[k - lo] = a[k];
            end
            22: begin
                r = a;
                for (int k = lo; k <= hi; k++) r[k] = b[k - lo];
            end
            23: begin
                for (int k = 31; k >= 0; k--) if (b[k]) begin r = 32'(k); break; end
            end
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic do_op(string req, int opc, bit isel, logic [31:0] s1, logic [31:0] s2,
                         logic [31:0] im, int lo, int hi, bit v);
        logic [31:0] exp;
        bit co;
        @(negedge clk);
        op_valid = v; opcode = 5'(opc); use_imm = isel;
        src1 = s1; src2 = s2; imm = im; fld_lo = 5'(lo); fld_hi = 5'(hi);
        #1;
        exp = model(opc, s1, isel ? im : s2, lo, hi, m_flag, co);
        chk(req, "result", result, exp);
        chk(req, "carry", {31'd0, carry}, {31'd0, m_flag});
        if (v && opc >= 1 && opc <= 4) m_flag = co;
    endtask

    task automatic op(string req, int opc, logic [31:0] a, logic [31:0] b);
        do_op(req, opc, 1'b0, a, b, 32'hDEAD_BEEF, 0, 0, 1'b1);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R4", "reset carry", {31'd0, carry}, 32'd0);
        rst_n = 1'b1;

        // R1 operand source selection
        do_op("R1", 1, 1'b1, 32'd10, 32'hFFFF_FFFF, 32'd5, 0, 0, 1'b1);
        do_op("R1", 1, 1'b0, 32'd10, 32'd5, 32'hFFFF_FFFF, 0, 0, 1'b1);
        do_op("R1", 7, 1'b1, 32'hF0F0_0000, 32'h1234_5678, 32'h0F0F_0000, 0, 0, 1'b1);

        // R2 low-word add and subtract
        op("R2", 1, 32'hFFFF_FFFF, 32'd1);
        op("R2", 1, 32'd7, 32'd8);
        op("R2", 3, 32'd1, 32'd2);
        op("R2", 3, 32'd9, 32'd9);

        // R3 64-bit chains with unrelated ops between the two halves
        op("R3", 1, 32'hFFFF_FFFF, 32'd1);
        op("R3", 5, 32'h1234_5678, 32'h0000_FFFF);
        do_op("R3", 3, 1'b0, 32'd0, 32'd0, 32'd0, 0, 0, 1'b0);
        op("R3", 2, 32'hFFFF_FFFF, 32'd0);
        op("R3", 2, 32'd4, 32'd3);
        op("R3", 3, 32'd0, 32'd1);
        op("R3", 9, 32'd1, 32'd4);
        op("R3", 4, 32'd0, 32'd0);
        op("R3", 4, 32'd5, 32'd2);

        // R4 flag hold when not valid or not arithmetic
        op("R4", 1, 32'h8000_0000, 32'h8000_0000);
        do_op("R4", 1, 1'b0, 32'd1, 32'd1, 32'd0, 0, 0, 1'b0);
        op("R4", 16, 32'd1, 32'd1);
        op("R4", 0, 32'd1, 32'd1);
        op("R4", 1, 32'd1, 32'd1);
        op("R4", 0, 32'd0, 32'd0);

        // R5
        op("R5", 8, 32'h1111_1111, 32'h0000_FFFF);
        op("R5", 17, 32'hFFFF_FFFF, 32'h00FF_00FF);
        op("R5", 6, 32'hA000_0000, 32'h0000_000A);
        // R6
        op("R6", 11, 32'h8000_0010, 32'd4);
        op("R6", 10, 32'h8000_0010, 32'd4);
        op("R6", 12, 32'h8000_0001, 32'd1);
        op("R6", 12, 32'h1234_5678, 32'd0);
        op("R6", 9, 32'h0000_0003, 32'd31);
        op("R6", 11, 32'h7FFF_FFFF, 32'd31);
        // R7
        op("R7", 13, 32'hABCD_12FF, 32'h9876_54FF);
        op("R7", 13, 32'h0000_0010, 32'h0000_0010);
        // R8
        op("R8", 14, 32'h8000_0000, 32'd1);
        op("R8", 15, 32'h8000_0000, 32'd1);
        op("R8", 16, 32'd3, 32'd3);
        op("R8", 16, 32'hFFFF_FFFF, 32'd0);
        op("R8", 16, 32'd0, 32'hFFFF_FFFF);
        // R9
        op("R9", 18, 32'd0, 32'h0000_003F);
        op("R9", 18, 32'hFFFF_FFFF, 32'h0000_001F);
        op("R9", 19, 32'd0, 32'd7);
        op("R9", 20, 32'hFFFF_FFFF, 32'd0);
        // R10
        do_op("R10", 21, 1'b0, 32'hABCD_1234, 32'd0, 32'd0, 8, 15, 1'b1);
        do_op("R10", 21, 1'b0, 32'hABCD_1234, 32'd0, 32'd0, 0, 31, 1'b1);
        do_op("R10", 21, 1'b0, 32'hABCD_1234, 32'd0, 32'd0, 9, 3, 1'b1);
        // R11
        do_op("R11", 22, 1'b0, 32'hFFFF_FFFF, 32'h0000_0000, 32'd0, 4, 11, 1'b1);
        do_op("R11", 22, 1'b1, 32'h0000_0000, 32'd0, 32'hFFFF_FFFF, 31, 31, 1'b1);
        do_op("R11", 22, 1'b0, 32'h1357_9BDF, 32'hFFFF_FFFF, 32'd0, 20, 2, 1'b1);
        // R12
        op("R12", 23, 32'hFFFF_FFFF, 32'd0);
        op("R12", 23, 32'd0, 32'd1);
        op("R12", 23, 32'd0, 32'h8000_0000);
        op("R12", 23, 32'd0, 32'h0001_0F00);
        // R13
        op("R13", 27, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        op("R13", 31, 32'h1, 32'h2);
        op("R13", 24, 32'h1, 32'h2);

        // random mix, all requirements R1 to R13
        for (int n = 0; n < 2000; n++) begin
            do_op("RAND", int'($urandom_range(0, 31)), 1'($urandom),
                  $urandom, $urandom, $urandom,
                  int'($urandom_range(0, 31)), int'($urandom_range(0, 31)),
                  ($urandom_range(0, 3) != 0));
        end

        // R4 reset clears a set flag
        op("R4", 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        @(negedge clk);
        chk("R4", "flag set before reset", {31'd0, carry}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R4", "flag after reset", {31'd0, carry}, 32'd0);
        m_flag = 0;
        rst_n = 1'b1;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule